// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two `WIDTH`-bit two's-complement numbers and returns their `2*WIDTH`-bit signed product. It handles one multiplier bit per clock. In each cycle it looks at the current multiplier LSB together with the bit shifted out on the previous step. From that pair it adds the multiplicand to the accumulator, subtracts it, or leaves the accumulator alone. It then arithmetic-shifts the accumulator, the multiplier register and the saved bit right by one place, treating them as a single register.

A one-cycle `start_i` pulse captures both operands while the block is idle. `busy_o` then stays high for exactly `WIDTH` cycles, and `done_o` flags the cycle in which the product first appears. The product stays on `product_o` until the next start is accepted. Both operand signs take the same path, so neither operand is complemented first. The accumulator is one bit wider than the operands, so the most negative multiplicand does not overflow it.

Top module: `booth_seq_mult`

## Requirements
- R1: After reset, `busy_o` = 0, `done_o` = 0 and `product_o` = 0.
- R2: A `start_i` sampled high while `busy_o` is low captures both operands. `busy_o` is then high for exactly `WIDTH` clock cycles. In the cycle after those, `busy_o` is low and `done_o` is high.
- R3: `done_o` is high for one cycle only for each accepted start.
- R4: When `done_o` is high, `product_o` equals the signed product of the captured multiplicand and multiplier, for every pair of `WIDTH`-bit two's-complement operands.
- R5: The step control uses the pair {multiplier LSB, saved bit}, with a 0 as the saved bit on the first step. The pair 01 adds the multiplicand and 10 subtracts it; 00 and 11 change nothing. A multiplier of -1 therefore gives the negated multiplicand.
- R6: The accumulator is `WIDTH+1` bits, so the most negative multiplicand still gives the correct product: -16 × -16 = 256 and -16 × 15 = -240 at `WIDTH` = 5.
- R7: `start_i` has no effect while `busy_o` is high. The product reported is the one for the operands captured first.
- R8: While idle with `start_i` low, `product_o` holds its value. A start sampled in the `done_o` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| mcand_i | input | WIDTH | Multiplicand, two's complement |
| mplier_i | input | WIDTH | Multiplier, two's complement |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle flag: product valid |
| product_o | output | 2*WIDTH | Signed product |

## Verification
The hardest case to reach is the accumulator going past the `WIDTH`-bit signed range partway through the iterations. This happens only when the multiplicand is the most negative value and a subtraction step comes first. At the default width the bench sweeps all 1024 operand pairs, so every such sequence is covered, and it also checks the two most-negative cases separately. It reaches ignored starts and a back-to-back start in the done cycle by driving `start_i` with different operands while busy and exactly in the done cycle.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    STEP_KEEP = 2'd0,
    STEP_ADD  = 2'd1,
    STEP_SUB  = 2'd2
  } step_op_e;

  // Bit pair {current multiplier LSB, previously shifted-out bit}
  function automatic step_op_e pair_to_op(input logic lsb, input logic prev);
    case ({lsb, prev})
      2'b01:   return STEP_ADD;
      2'b10:   return STEP_SUB;
      default: return STEP_KEEP;
    endcase
  endfunction
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic     lsb_i,
  input  logic     prev_i,
  output step_op_e op_o,
  output logic     add_o,
  output logic     sub_o
);
  always_comb begin
    op_o  = pair_to_op(lsb_i, prev_i);
    add_o = (op_o == STEP_ADD);
    sub_o = (op_o == STEP_SUB);
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 5,
  localparam int EW = WIDTH + 1
) (
  input  logic [EW-1:0]    acc_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  step_op_e         op_i,
  output logic [EW-1:0]    sum_o
);
  function automatic logic [EW-1:0] sext(input logic [WIDTH-1:0] v);
    return {v[WIDTH-1], v};
  endfunction

  function automatic logic [EW-1:0] apply(input logic [EW-1:0] a,
                                          input logic [WIDTH-1:0] m,
                                          input step_op_e op);
    case (op)
      STEP_ADD: return a + sext(m);
      STEP_SUB: return a + ~sext(m) + EW'(1);
      default:  return a;
    endcase
  endfunction

  always_comb sum_o = apply(acc_i, mcand_i, op_i);
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
  parameter int WIDTH = 5,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic          last_step;

  assign load_o    = start_i && !busy_q;
  assign step_o    = busy_q;
  assign last_step = busy_q && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_step;
      if (load_o) begin
        cnt_q  <= CW'(WIDTH);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q  <= cnt_q - CW'(1);
        busy_q <= !last_step;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r2_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);
  a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0) && (cnt_q <= CW'(WIDTH)));
  a_r7_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_step) |=> busy_q);
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 5,
  localparam int EW = WIDTH + 1,
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [PW-1:0]    product_o
);
  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] mq_q;
  logic [EW-1:0]    acc_q;
  logic             prev_q;

  logic             load_w, step_w;
  step_op_e         op_w;
  logic             add_w, sub_w;
  logic [EW-1:0]    sum_w;

  booth_seq_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .load_o(load_w), .step_o(step_w), .busy_o(busy_o), .done_o(done_o)
  );

  booth_recode recode_i (
    .lsb_i(mq_q[0]), .prev_i(prev_q), .op_o(op_w), .add_o(add_w), .sub_o(sub_w)
  );

  booth_addsub #(.WIDTH(WIDTH)) addsub_i (
    .acc_i(acc_q), .mcand_i(mcand_q), .op_i(op_w), .sum_o(sum_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      mq_q    <= '0;
      acc_q   <= '0;
      prev_q  <= 1'b0;
    end else if (load_w) begin
      mcand_q <= mcand_i;
      mq_q    <= mplier_i;
      acc_q   <= '0;
      prev_q  <= 1'b0;
    end else if (step_w) begin
      acc_q   <= {sum_w[EW-1], sum_w[EW-1:1]};
      mq_q    <= {sum_w[0], mq_q[WIDTH-1:1]};
      prev_q  <= mq_q[0];
    end
  end

  assign product_o = {acc_q[WIDTH-1:0], mq_q};

  a_r5_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({add_w, sub_w}));
  a_r7_operand_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(mcand_q));
  a_r8_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(product_o));
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (acc_q[EW-1] == acc_q[WIDTH-1]));
endmodule

// File: tb/booth_seq_mult_tb.sv
module booth_seq_mult_tb_top;
  localparam int W = 5;
  localparam int PW = 2 * W;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] mcand = '0, mplier = '0;
  logic busy, done;
  logic [PW-1:0] product;
  int checks = 0, errors = 0;

  always #(PERIOD / 2) clk = !clk;

  booth_seq_mult #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mcand_i(mcand),
    .mplier_i(mplier), .busy_o(busy), .done_o(done), .product_o(product)
  );

  function automatic int sval(input logic [W-1:0] v);
    return (v[W-1]) ? int'(v) - (1 << W) : int'(v);
  endfunction

  function automatic int pval(input logic [PW-1:0] v);
    return (v[PW-1]) ? int'(v) - (1 << PW) : int'(v);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive a start at the coming edge; then walk the busy window and the done cycle.
  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                     input bit noisy, input string tag);
    int nbusy = 0;
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = noisy;
    if (noisy) begin mcand = ~a; mplier = b + 1'b1; end
    for (int i = 0; i < W; i++) begin
      if (busy) nbusy++;
      if (i == 2) start = 1'b0;
      @(negedge clk);
    end
    chk(nbusy == W, "R2 busy length", nbusy, W);
    chk(!busy && done, "R2 done after busy", {busy, done}, 1);
    chk(pval(product) == sval(a) * sval(b), tag, pval(product), sval(a) * sval(b));
    start = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [PW-1:0] held;
    #(PERIOD * 2 + 1ns);
    chk(!busy && !done && product == '0, "R1 reset state", product, 0);
    rst_n = 1'b1;

    // R4, R5: every operand pair (includes mplier -1 and pair-rule sequences)
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run(W'(a), W'(b), 1'b0, "R4 product");

    // R5 multiplier of -1: single subtract step then only shifts
    run(5'd7, 5'b11111, 1'b0, "R5 neg one");
    // R6 most negative multiplicand
    run(5'b10000, 5'b10000, 1'b0, "R6 min x min");
    run(5'b10000, 5'd15, 1'b0, "R6 min x max");

    // R3: done drops next cycle
    @(negedge clk);
    chk(!done, "R3 done single", done, 0);

    // R7: start held with other operands while busy is ignored
    run(5'd11, 5'b10110, 1'b1, "R7 ignore start");

    // R8: product holds while idle
    held = product;
    repeat (4) @(negedge clk);
    chk(product == held, "R8 hold", pval(product), pval(held));

    // R8: start in the done cycle is accepted
    run(5'd9, 5'd3, 1'b0, "R8 first");
    mcand = 5'b11010; mplier = 5'd13; start = 1'b1;   // in done cycle
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R8 start in done accepted", busy, 1);
    repeat (W) @(negedge clk);
    chk(done && pval(product) == -6 * 13, "R8 back to back", pval(product), -78);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule